// File: doc/BRIEF.md
# ARINC 429 receive bit validator

This block sits behind the two comparator outputs of a bipolar ARINC 429 receive line and turns the sampled line levels into 32-bit words. The positive comparator (`line_a`) and the negative comparator (`line_b`) are sampled at a 1 MHz rate. In high-speed mode every clock is a sample. In low-speed mode one clock in eight is a sample. Each sample is pushed into three short history registers, one each for One, Zero and Null. A bit is recognised only when a settled level is followed by a settled return to Null. This rejects pulses that are too short.

With discrimination enabled, successive bits must be spaced within a fixed window of samples, or the partial word is thrown away. With discrimination disabled, any 32 recognised bits form a word, however far apart they are. In both cases the line must show a Null word gap, counted in periodic checks, before a new word may start. A complete word is presented for one clock on `word_valid` together with its 32 bits. Parity, label filtering and storage belong to the blocks downstream.

Top module: `arinc_rx_validator`

## Requirements
- R1: A sample with `line_a`=1, `line_b`=0 is a One (data bit value 1). A sample with `line_a`=0, `line_b`=1 is a Zero (value 0). A sample with both low is a Null. In high-speed mode (`low_speed`=0) every clock is a sample.
- R2: A data bit is recognised when at least 3 consecutive One (or Zero) samples inside the 10-sample history are followed by exactly 3 settled Null samples. A pulse of only 2 samples produces no bit.
- R3: With `discrim_en`=1, bit k (k from 2 to 32) must arrive between 8 and 12 samples after bit k-1, both limits included. Otherwise the partial word is dropped, no `word_valid` is produced, and the word gap must be counted again.
- R4: With `discrim_en`=0, bit spacing is not checked, so words with 6-sample or 20-sample bit periods are accepted.
- R5: After a word ends, is aborted, or a bit is refused, a gap timer examines the history every 10 samples. If there are 3 Nulls at both the oldest and the newest end, it increments a gap count. A first bit is accepted only when the count has reached 3. An earlier bit is dropped and restarts the count.
- R6: A completed word raises `word_valid` for exactly one clock. `word_data[0]` holds the first bit received and `word_data[31]` holds the last.
- R7: After reset `word_valid` is 0 and the gap condition counts as met, so the first word after reset is accepted.
- R8: When a bit arrives on the same sample as a gap-timer check, the bit is judged against the count before that check. With no Null gap between two 10-sample words, the second word is refused.
- R9: In low-speed mode (`low_speed`=1) a sample is taken once every 8 clocks. All sample counts of R2, R3 and R5 then apply to those samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_a | input | 1 | Positive-side comparator output |
| line_b | input | 1 | Negative-side comparator output |
| low_speed | input | 1 | 1 selects one sample per 8 clocks |
| discrim_en | input | 1 | 1 enforces the 8 to 12 sample bit spacing |
| word_valid | output | 1 | One-clock strobe for a completed word |
| word_data | output | 32 | Received word, first bit in bit 0 |

## Verification
The arrival of a data bit and a tick of the word-gap timer can land on the same sample. The bench forces this by sending a 10-sample word straight after another with no extra Null. The first bit of the second word then appears exactly 10 samples after the last bit of the first, which is when the restarted gap timer fires. The second word must be refused and the next word after a proper gap must be accepted. The gap boundary is also probed with 27 extra Null samples, which must fail the third check, and with 28, which must pass it.

// File: rtl/arinc_rxv_pkg.sv
// Package: shared defaults and line classification for the ARINC 429
// receive bit validator. Assumes comparator outputs are already synchronous.
package arinc_rxv_pkg;

    localparam int WORD_BITS_D  = 32;  // bits per word
    localparam int SR_LEN_D     = 10;  // sampling history length
    localparam int RUN_LEN_D    = 3;   // identical samples for a settled level
    localparam int SPC_MIN_D    = 8;   // minimum samples between bits
    localparam int SPC_MAX_D    = 12;  // maximum samples between bits
    localparam int GAP_PERIOD_D = 10;  // samples between gap checks
    localparam int GAP_NEED_D   = 3;   // gap checks needed before a word
    localparam int LS_DIV_D     = 8;   // clocks per sample in low speed

    typedef enum logic [1:0] {
        LV_NULL = 2'd0,
        LV_ONE  = 2'd1,
        LV_ZERO = 2'd2,
        LV_BAD  = 2'd3
    } line_lvl_t;

    // Map the two comparator outputs to a line level.
    function automatic line_lvl_t classify(input logic pos, input logic neg);
        case ({pos, neg})
            2'b00:   return LV_NULL;
            2'b10:   return LV_ONE;
            2'b01:   return LV_ZERO;
            default: return LV_BAD;
        endcase
    endfunction

endpackage

// File: rtl/arinc_rxv_sampler.sv
// Sampler: makes the sample strobe (every clock, or every LS_DIV clocks in
// low speed) and keeps a history register per line level.
// Assumes line inputs are stable around the strobe.
module arinc_rxv_sampler
    import arinc_rxv_pkg::*;
#(
    parameter int SR_LEN  = SR_LEN_D,
    parameter int RUN_LEN = RUN_LEN_D,
    parameter int LS_DIV  = LS_DIV_D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_a,
    input  logic                      line_b,
    input  logic                      low_speed,
    output logic                      fresh,
    output logic [SR_LEN-RUN_LEN-1:0] one_up,
    output logic [SR_LEN-RUN_LEN-1:0] zero_up,
    output logic [RUN_LEN:0]          null_low,
    output logic [RUN_LEN-1:0]        null_top
);
    localparam int DIV_W = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LS_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic              s_tick;
    logic [SR_LEN-1:0] one_sr, zero_sr, null_sr;
    line_lvl_t         lvl;

    assign lvl    = classify(line_a, line_b);
    assign s_tick = !low_speed || (div_q == DIV_LAST);

    // Free-running divider for the low-speed sample strobe.
    always_ff @(posedge clk) begin : p_div
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end

    // Shift the current level into the histories on each strobe.
    always_ff @(posedge clk) begin : p_hist
        if (!rst_n) begin
            one_sr  <= '0;
            zero_sr <= '0;
            null_sr <= '0;
            fresh   <= 1'b0;
        end else begin
            fresh <= s_tick;
            if (s_tick) begin
                one_sr  <= {one_sr[SR_LEN-2:0],  lvl == LV_ONE};
                zero_sr <= {zero_sr[SR_LEN-2:0], lvl == LV_ZERO};
                null_sr <= {null_sr[SR_LEN-2:0], lvl == LV_NULL};
            end
        end
    end

    assign one_up   = one_sr[SR_LEN-1:RUN_LEN];
    assign zero_up  = zero_sr[SR_LEN-1:RUN_LEN];
    assign null_low = null_sr[RUN_LEN:0];
    assign null_top = null_sr[SR_LEN-1 -: RUN_LEN];

    AST_LS_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (low_speed && s_tick) |=> (!s_tick || !low_speed)) else $error("low-speed strobe repeated"); // R9

endmodule

// File: rtl/arinc_rxv_detect.sv
// Detector: finds a data bit (settled One/Zero run in the older part of the
// history followed by a just-settled Null run) and a gap Null (Null runs at
// both ends of the history). Outputs are valid only on fresh samples.
module arinc_rxv_detect #(
    parameter int SR_LEN  = 10,
    parameter int RUN_LEN = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fresh,
    input  logic [SR_LEN-RUN_LEN-1:0] one_up,
    input  logic [SR_LEN-RUN_LEN-1:0] zero_up,
    input  logic [RUN_LEN:0]          null_low,
    input  logic [RUN_LEN-1:0]        null_top,
    output logic                      bit_evt,
    output logic                      bit_val,
    output logic                      gap_null
);
    localparam int NPOS = SR_LEN - 2 * RUN_LEN + 1;
    localparam logic [RUN_LEN:0] SETTLE = {1'b0, {RUN_LEN{1'b1}}};

    logic [NPOS-1:0] one_hit, zero_hit;
    logic            any_one, any_zero, settle;

    // One run detector per start position in the older history.
    for (genvar i = 0; i < NPOS; i++) begin : g_run
        assign one_hit[i]  = &one_up[i +: RUN_LEN];
        assign zero_hit[i] = &zero_up[i +: RUN_LEN];
    end

    assign any_one  = |one_hit;
    assign any_zero = |zero_hit;
    assign settle   = (null_low == SETTLE);
    assign bit_evt  = fresh && settle && (any_one ^ any_zero);
    assign bit_val  = any_one;
    assign gap_null = (&null_top) && (&null_low[RUN_LEN-1:0]);

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |=> !bit_evt) else $error("bit seen twice"); // R2

endmodule

// File: rtl/arinc_rxv_ctrl.sv
// Controller: measures bit spacing, runs the word-gap timer and count,
// assembles bits into a word and emits the one-clock word strobe.
// Assumes bit_evt is only asserted on fresh samples.
module arinc_rxv_ctrl #(
    parameter int WORD_BITS  = 32,
    parameter int SPC_MIN    = 8,
    parameter int SPC_MAX    = 12,
    parameter int GAP_PERIOD = 10,
    parameter int GAP_NEED   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fresh,
    input  logic                 bit_evt,
    input  logic                 bit_val,
    input  logic                 gap_null,
    input  logic                 discrim_en,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_data
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam int SPC_W = $clog2(SPC_MAX + 1) + 1;
    localparam int TMR_W = $clog2(GAP_PERIOD);
    localparam int GAP_W = $clog2(GAP_NEED + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
    localparam logic [SPC_W-1:0] SPC_LO   = SPC_W'(SPC_MIN);
    localparam logic [SPC_W-1:0] SPC_HI   = SPC_W'(SPC_MAX);
    localparam logic [SPC_W-1:0] SPC_SAT  = '1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(GAP_PERIOD - 1);
    localparam logic [GAP_W-1:0] GAP_OK   = GAP_W'(GAP_NEED);

    logic [CNT_W-1:0]     bit_cnt;
    logic [SPC_W-1:0]     spc;
    logic [TMR_W-1:0]     gap_tmr;
    logic [GAP_W-1:0]     gap_cnt;
    logic [WORD_BITS-1:0] shreg, shreg_nxt;
    logic                 spacing_ok;

    assign spacing_ok = (spc >= SPC_LO) && (spc <= SPC_HI);

    // Word image with the incoming bit placed at its arrival index.
    always_comb begin : p_nxt
        shreg_nxt          = shreg;
        shreg_nxt[bit_cnt] = bit_val;
    end

    // Spacing counter, gap timer and word assembly.
    always_ff @(posedge clk) begin : p_ctrl
        if (!rst_n) begin
            bit_cnt    <= '0;
            spc        <= '0;
            gap_tmr    <= '0;
            gap_cnt    <= GAP_OK;
            shreg      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (fresh) begin
                if (bit_evt)           spc <= SPC_W'(1);
                else if (spc != SPC_SAT) spc <= spc + 1'b1;

                if (gap_cnt != GAP_OK) begin
                    if (gap_tmr == TMR_LAST) begin
                        gap_tmr <= '0;
                        if (gap_null) gap_cnt <= gap_cnt + 1'b1;
                    end else begin
                        gap_tmr <= gap_tmr + 1'b1;
                    end
                end

                if (bit_evt) begin
                    if (bit_cnt == '0) begin
                        if (gap_cnt == GAP_OK) begin
                            shreg   <= shreg_nxt;
                            bit_cnt <= CNT_W'(1);
                        end else begin
                            gap_cnt <= '0;
                            gap_tmr <= '0;
                        end
                    end else if (discrim_en && !spacing_ok) begin
                        bit_cnt <= '0;
                        gap_cnt <= '0;
                        gap_tmr <= '0;
                    end else if (bit_cnt == LAST_IDX) begin
                        word_valid <= 1'b1;
                        word_data  <= shreg_nxt;
                        bit_cnt    <= '0;
                        gap_cnt    <= '0;
                        gap_tmr    <= '0;
                    end else begin
                        shreg   <= shreg_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid) else $error("strobe longer than a clock"); // R6
    AST_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_evt && bit_cnt == '0 && gap_cnt != GAP_OK) |=> (bit_cnt == '0 && !word_valid))
        else $error("bit accepted inside gap"); // R5
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt == GAP_OK && !bit_evt) |=> gap_cnt == GAP_OK) else $error("gap lost"); // R5
    AST_SPACING_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_evt && bit_cnt != '0 && discrim_en && !spacing_ok) |=> (bit_cnt == '0 && !word_valid))
        else $error("spacing violation kept"); // R3

endmodule

// File: rtl/arinc_rx_validator.sv
// Top: ARINC 429 receive bit validator. Samples the two comparator outputs,
// recognises bits, enforces spacing and word gap, and emits whole words.
// Assumes clk is the 1 MHz sampling clock and inputs are synchronous.
module arinc_rx_validator
    import arinc_rxv_pkg::*;
#(
    parameter int WORD_BITS  = WORD_BITS_D,
    parameter int SR_LEN     = SR_LEN_D,
    parameter int RUN_LEN    = RUN_LEN_D,
    parameter int SPC_MIN    = SPC_MIN_D,
    parameter int SPC_MAX    = SPC_MAX_D,
    parameter int GAP_PERIOD = GAP_PERIOD_D,
    parameter int GAP_NEED   = GAP_NEED_D,
    parameter int LS_DIV     = LS_DIV_D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_a,
    input  logic                 line_b,
    input  logic                 low_speed,
    input  logic                 discrim_en,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_data
);
    localparam int UP_W = SR_LEN - RUN_LEN;

    logic              fresh, bit_evt, bit_val, gap_null;
    logic [UP_W-1:0]   one_up, zero_up;
    logic [RUN_LEN:0]  null_low;
    logic [RUN_LEN-1:0] null_top;

    arinc_rxv_sampler #(.SR_LEN(SR_LEN), .RUN_LEN(RUN_LEN), .LS_DIV(LS_DIV)) u_smp (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .low_speed(low_speed), .fresh(fresh), .one_up(one_up),
        .zero_up(zero_up), .null_low(null_low), .null_top(null_top)
    );

    arinc_rxv_detect #(.SR_LEN(SR_LEN), .RUN_LEN(RUN_LEN)) u_det (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .one_up(one_up),
        .zero_up(zero_up), .null_low(null_low), .null_top(null_top),
        .bit_evt(bit_evt), .bit_val(bit_val), .gap_null(gap_null)
    );

    arinc_rxv_ctrl #(.WORD_BITS(WORD_BITS), .SPC_MIN(SPC_MIN), .SPC_MAX(SPC_MAX),
                     .GAP_PERIOD(GAP_PERIOD), .GAP_NEED(GAP_NEED)) u_ctl (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .bit_evt(bit_evt),
        .bit_val(bit_val), .gap_null(gap_null), .discrim_en(discrim_en),
        .word_valid(word_valid), .word_data(word_data)
    );

endmodule

// File: tb/tb_arinc_rx_validator.sv
module tb_arinc_rx_validator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_a = 1'b0;
    logic        line_b = 1'b0;
    logic        low_speed = 1'b0;
    logic        discrim_en = 1'b1;
    logic        word_valid;
    logic [31:0] word_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    arinc_rx_validator dut (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .low_speed(low_speed), .discrim_en(discrim_en),
        .word_valid(word_valid), .word_data(word_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Hold the present level for n samples.
    task automatic hold(input int n);
        repeat (n * (low_speed ? 8 : 1)) @(negedge clk);
    endtask

    // cls: 0 Null, 1 One, 2 Zero.
    task automatic set_line(input int cls);
        line_a = (cls == 1);
        line_b = (cls == 2);
    endtask

    task automatic idle(input int n);
        set_line(0);
        hold(n);
    endtask

    // Send 32 bits first-to-last from w[0]; push the word if it should pass.
    task automatic send_word(input logic [31:0] w, input int hi, input int nu,
                             input bit expect_ok, input string tag);
        if (expect_ok) begin
            exp_q.push_back(w);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < 32; i++) begin
            set_line(w[i] ? 1 : 2);
            hold(hi);
            set_line(0);
            hold(nu);
        end
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // Monitor: every strobe must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 R3 unexpected word", word_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(word_data === e, t, word_data, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_valid == 1'b0, "R7 reset strobe low", 32'(word_valid), 32'd0);

        // R7 R1 R6: first word after reset, 10-sample bits
        send_word(32'hA5C3_0F81, 5, 5, 1'b1, "R7 R1 R6 first word");
        idle(40);
        drained("R6 word delivered");

        // R3: spacing limits 8 and 12 accepted, 13 and 7 refused
        send_word(32'h1234_5678, 4, 4, 1'b1, "R3 spacing 8");
        idle(40);
        send_word(32'hFEDC_BA98, 6, 6, 1'b1, "R3 spacing 12");
        idle(40);
        send_word(32'h0F0F_F0F0, 6, 7, 1'b0, "R3 spacing 13");
        idle(40);
        drained("R3 spacing 13 dropped");
        send_word(32'h3333_CCCC, 3, 4, 1'b0, "R3 spacing 7");
        idle(40);
        drained("R3 spacing 7 dropped");

        // R2: a 2-sample pulse yields no bit, so the word breaks
        exp_q.delete();
        for (int i = 0; i < 32; i++) begin
            set_line(i[0] ? 1 : 2);
            hold(i == 4 ? 2 : 5);
            set_line(0);
            hold(i == 4 ? 8 : 5);
        end
        idle(40);
        drained("R2 short pulse word dropped");
        send_word(32'h8000_0001, 3, 3 + 4, 1'b1, "R2 min pulse 3 samples");
        idle(40);

        // R4: discrimination off accepts 20 and 6 sample periods
        discrim_en = 1'b0;
        send_word(32'hDEAD_BEEF, 5, 15, 1'b1, "R4 period 20");
        idle(40);
        send_word(32'h5A5A_0001, 3, 3, 1'b1, "R4 period 6");
        idle(40);
        discrim_en = 1'b1;
        drained("R4 words delivered");

        // R8 R5: back-to-back words, second refused, third accepted
        send_word(32'h0000_FFFF, 5, 5, 1'b1, "R8 word before");
        send_word(32'hFFFF_0000, 5, 5, 1'b0, "R8 no gap");
        idle(40);
        send_word(32'h1357_9BDF, 5, 5, 1'b1, "R8 R5 word after gap");
        idle(40);
        drained("R8 only gapped words");

        // R5: 27 extra Nulls too short, 28 enough
        send_word(32'h2468_ACE0, 5, 5, 1'b1, "R5 lead word");
        idle(27);
        send_word(32'hCAFE_F00D, 5, 5, 1'b0, "R5 gap 27");
        idle(40);
        drained("R5 gap 27 refused");
        send_word(32'h7777_1111, 5, 5, 1'b1, "R5 lead word two");
        idle(28);
        send_word(32'h0BAD_C0DE, 5, 5, 1'b1, "R5 gap 28");
        idle(40);
        drained("R5 gap 28 accepted");

        // R9: low speed, one sample per 8 clocks
        low_speed = 1'b1;
        idle(4);
        send_word(32'h9ABC_DEF0, 5, 5, 1'b1, "R9 low speed word");
        idle(40);
        send_word(32'h1111_EEEE, 6, 7, 1'b0, "R9 low speed spacing 13");
        idle(40);
        drained("R9 low speed spacing refused");
        send_word(32'h4242_2424, 5, 5, 1'b1, "R9 low speed recovery");
        idle(40);
        drained("R9 low speed delivered");

        done = 1'b1;
        report();
        $finish;
    end

endmodule